// File: doc/BRIEF.md
# Programmable CCD Clock Sequencer

This block produces all the timing waveforms for a column-parallel CCD camera from one fast system clock. The fast clock runs at 256 ticks per pixel period, counted by an 8-bit tick counter. Every generated signal has a programmable rising tick and a programmable falling tick, so the full shape of each waveform comes from configuration. Two groups of signals exist. The sensor group has four phase clocks and a transfer gate. The second group drives the readout front end: a reset control, an integrate control, an invert control and a sample strobe.

Configuration writes land in shadow registers. They become active only at a period boundary, so no waveform changes part way through a period. A start pulse launches one frame. The frame first freezes the sensor clocks for a programmed number of whole periods, which forms the integration or exposure interval. It then runs the sensor clocks for a programmed number of row periods, and raises a row-valid flag for each of those periods. The front-end controls run in every period regardless of the frame state, so the downstream sample and conversion chain never stops. The row-valid flag tells the capture logic which samples hold real charge and which samples were taken while the sensor was frozen.

Top module: `ccd_clock_seq`

## Requirements
- R1: A free-running tick counter wraps every 256 fast-clock cycles. Each output shows the window state of the tick one fast clock earlier, and the first cycle after reset release shows tick 0.
- R2: A signal is high from its rising tick, inclusive, up to its falling tick, exclusive. If the two ticks are equal, the signal stays low for the whole period. If the rising tick is larger than the falling tick, the pulse wraps across the period boundary.
- R3: Phase 3 is always the complement of phase 1, and phase 4 is always the complement of phase 2. This also holds during reset, where phases 1 and 2 and every other output are 0, and phases 3 and 4 are 1.
- R4: Edge registers sit at write address 2k (rising tick) and 2k+1 (falling tick). Signal index k runs 0 phase1, 1 phase2, 2 transfer gate, 3 fe reset, 4 first integrate, 5 second integrate, 6 invert, 7 sample. A write takes effect only from the first period that starts after the write.
- R5: A start pulse taken while idle launches a frame at the next period boundary. The frame first holds for the count at address 16. During those periods, phase1, phase2 and the transfer gate keep the level their windows have at tick 0, and phases 3 and 4 keep the complements.
- R6: After the hold, the sensor clocks run for the row count at address 17. The row-valid output is high for exactly those whole periods, and then the block returns to idle.
- R7: The front-end outputs follow their windows in every period, whatever the frame state, including edge changes made during a hold.
- R8: A start pulse received while a frame is in progress is ignored.
- R9: A hold count of 0 starts the row periods at once. A row count of 0 ends the frame after the hold, with no valid period.
- R10: After reset the ticks are: phase1 0 to 128, phase2 64 to 192, transfer gate 192 to 224, fe reset 0 to 16, first integrate 24 to 88, invert 96 to 200, second integrate 104 to 168, sample 176 to 184. The integrate output is the OR of its two windows, so reset, both equal-length integrations with the invert around the second, and the sample occur in that order.
- R11: When idle, the sensor clocks run and row-valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 256 ticks per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| frame_start | input | 1 | Single-cycle frame launch request |
| ccd_p1 | output | 1 | Sensor phase 1 |
| ccd_p2 | output | 1 | Sensor phase 2 |
| ccd_p3 | output | 1 | Sensor phase 3, complement of phase 1 |
| ccd_p4 | output | 1 | Sensor phase 4, complement of phase 2 |
| ccd_tg | output | 1 | Sensor transfer gate |
| fe_rst | output | 1 | Front-end amplifier reset |
| fe_int | output | 1 | Front-end integrate window |
| fe_inv | output | 1 | Front-end invert control |
| fe_smp | output | 1 | Front-end sample strobe |
| row_valid | output | 1 | High during periods that read real charge |

## Verification
Count n as the rising edges since reset release. The output seen after edge n is for tick (n-1) mod 256 of period (n-1)/256. A write or start sampled at edge w applies to period w/256+1, rounded down; the bench never drives these inputs on a boundary edge. The driver pushes each expected output vector into a queue, stamped with its exact edge index, once the stimulus for the coming period is complete. The monitor pops the vector whose stamp matches the current edge count and compares all ten outputs. Every tick of every period is checked, so a one-cycle shift in any edge or in the hold and row timing shows up as a mismatch.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    // number of independently programmed waveforms
    localparam int NSIG = 8;

    typedef enum logic [2:0] {
        SIG_PH1   = 3'd0,
        SIG_PH2   = 3'd1,
        SIG_TG    = 3'd2,
        SIG_FRST  = 3'd3,
        SIG_FINTA = 3'd4,
        SIG_FINTB = 3'd5,
        SIG_FINV  = 3'd6,
        SIG_FSMP  = 3'd7
    } sig_e;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_READ = 2'd2
    } mode_e;

    typedef struct packed {
        logic ph1;
        logic ph2;
        logic tg;
    } ccd_lvl_t;

    typedef struct packed {
        logic rst;
        logic integ;
        logic inv;
        logic smp;
    } fe_lvl_t;

    // reset-time edge placement, expressed for 256 ticks and scaled to tick_w
    function automatic int dflt_tick(int k, bit is_fall, int tick_w);
        int v;
        case (k)
            0:       v = is_fall ? 128 : 0;
            1:       v = is_fall ? 192 : 64;
            2:       v = is_fall ? 224 : 192;
            3:       v = is_fall ? 16  : 0;
            4:       v = is_fall ? 88  : 24;
            5:       v = is_fall ? 168 : 104;
            6:       v = is_fall ? 200 : 96;
            7:       v = is_fall ? 184 : 176;
            default: v = 0;
        endcase
        return (v << tick_w) >> 8;
    endfunction

endpackage

// File: rtl/ccdseq_tick.sv
module ccdseq_tick #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TICK_W-1:0] tick_o,
    output logic              wrap_o
);
    localparam logic [TICK_W-1:0] LAST_TICK = '1;

    always_ff @(posedge clk) begin
        if (rst) tick_o <= '0;
        else     tick_o <= tick_o + TICK_W'(1);
    end

    assign wrap_o = (tick_o == LAST_TICK);

endmodule

// File: rtl/ccdseq_cfg.sv
module ccdseq_cfg
    import ccdseq_pkg::*;
#(
    parameter int TICK_W = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [TICK_W-1:0] on_o  [NSIG],
    output logic [TICK_W-1:0] off_o [NSIG],
    output logic [CNT_W-1:0]  hold_n_o,
    output logic [CNT_W-1:0]  rows_n_o
);
    localparam int A_HOLD = 2 * NSIG;
    localparam int A_ROWS = 2 * NSIG + 1;

    logic [TICK_W-1:0] sh_on  [NSIG];
    logic [TICK_W-1:0] sh_off [NSIG];

    // shadow copy: written by the register port at any time
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSIG; k++) begin
                sh_on[k]  <= TICK_W'(dflt_tick(k, 1'b0, TICK_W));
                sh_off[k] <= TICK_W'(dflt_tick(k, 1'b1, TICK_W));
            end
            hold_n_o <= '0;
            rows_n_o <= '0;
        end else if (we_i) begin
            for (int k = 0; k < NSIG; k++) begin
                if (addr_i == ADDR_W'(2 * k))     sh_on[k]  <= wdata_i[TICK_W-1:0];
                if (addr_i == ADDR_W'(2 * k + 1)) sh_off[k] <= wdata_i[TICK_W-1:0];
            end
            if (addr_i == ADDR_W'(A_HOLD)) hold_n_o <= wdata_i[CNT_W-1:0];
            if (addr_i == ADDR_W'(A_ROWS)) rows_n_o <= wdata_i[CNT_W-1:0];
        end
    end

    // active copy: follows the shadow only on the last tick of a period
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSIG; k++) begin
                on_o[k]  <= TICK_W'(dflt_tick(k, 1'b0, TICK_W));
                off_o[k] <= TICK_W'(dflt_tick(k, 1'b1, TICK_W));
            end
        end else if (wrap_i) begin
            for (int k = 0; k < NSIG; k++) begin
                on_o[k]  <= sh_on[k];
                off_o[k] <= sh_off[k];
            end
        end
    end

    for (genvar g = 0; g < NSIG; g++) begin : g_chk
        // R4: active edges move only across a period boundary
        p_cfg_boundary_r4: assert property (@(posedge clk) disable iff (rst)
            !$past(wrap_i) |-> ($stable(on_o[g]) && $stable(off_o[g])));
    end

endmodule

// File: rtl/ccdseq_frame.sv
module ccdseq_frame
    import ccdseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] hold_n_i,
    input  logic [CNT_W-1:0] rows_n_i,
    output mode_e            mode_o
);
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] rows_q;
    logic             pend_q;
    logic             last_w;

    assign last_w = (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= MODE_IDLE;
            left_q <= '0;
            rows_q <= '0;
            pend_q <= 1'b0;
        end else if (wrap_i) begin
            pend_q <= 1'b0;
            unique case (mode_o)
                MODE_IDLE: begin
                    if (pend_q || start_i) begin
                        rows_q <= rows_n_i;
                        if (hold_n_i != '0) begin
                            mode_o <= MODE_HOLD;
                            left_q <= hold_n_i;
                        end else if (rows_n_i != '0) begin
                            mode_o <= MODE_READ;
                            left_q <= rows_n_i;
                        end
                    end
                end
                MODE_HOLD: begin
                    if (last_w) begin
                        if (rows_q != '0) begin
                            mode_o <= MODE_READ;
                            left_q <= rows_q;
                        end else begin
                            mode_o <= MODE_IDLE;
                        end
                    end else begin
                        left_q <= left_q - CNT_W'(1);
                    end
                end
                MODE_READ: begin
                    if (last_w) mode_o <= MODE_IDLE;
                    else        left_q <= left_q - CNT_W'(1);
                end
                default: mode_o <= MODE_IDLE;
            endcase
        end else if (start_i && mode_o == MODE_IDLE) begin
            pend_q <= 1'b1;
        end
    end

    // R5: a frame in progress always has periods left to run
    p_busy_left_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_o != MODE_IDLE) |-> (left_q != '0));

    // R6: frame state changes only across a period boundary
    p_mode_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_o != $past(mode_o)) |-> $past(wrap_i));

    // R8: a start during a frame leaves no pending launch behind
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_o != MODE_IDLE) |=> !pend_q);

endmodule

// File: rtl/ccdseq_wave.sv
module ccdseq_wave
    import ccdseq_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TICK_W-1:0] tick_i,
    input  logic [TICK_W-1:0] on_i  [NSIG],
    input  logic [TICK_W-1:0] off_i [NSIG],
    input  mode_e             mode_i,
    output ccd_lvl_t          ccd_o,
    output logic              p3_o,
    output logic              p4_o,
    output fe_lvl_t           fe_o,
    output logic              valid_o
);
    logic [NSIG-1:0] hit;
    logic [NSIG-1:0] hit0;
    ccd_lvl_t        run_lvl;
    ccd_lvl_t        hold_lvl;
    ccd_lvl_t        ccd_nx;
    fe_lvl_t         fe_nx;

    for (genvar g = 0; g < NSIG; g++) begin : g_win
        // window at the current tick; wraps when rise > fall, empty when equal
        assign hit[g] = (on_i[g] < off_i[g]) ? (tick_i >= on_i[g] && tick_i < off_i[g]) :
                        (on_i[g] > off_i[g]) ? (tick_i >= on_i[g] || tick_i < off_i[g]) :
                        1'b0;
        // window evaluated at tick 0, used to freeze the sensor clocks
        assign hit0[g] = (on_i[g] < off_i[g]) ? (on_i[g] == '0) :
                         (on_i[g] > off_i[g]) ? (off_i[g] != '0) :
                         1'b0;

        // R2: equal edges never produce a pulse
        p_empty_win_r2: assert property (@(posedge clk) disable iff (rst)
            (on_i[g] == off_i[g]) |-> !hit[g]);
    end

    always_comb begin
        run_lvl  = '{ph1: hit[SIG_PH1],  ph2: hit[SIG_PH2],  tg: hit[SIG_TG]};
        hold_lvl = '{ph1: hit0[SIG_PH1], ph2: hit0[SIG_PH2], tg: hit0[SIG_TG]};
        ccd_nx   = (mode_i == MODE_HOLD) ? hold_lvl : run_lvl;
        fe_nx    = '{rst:   hit[SIG_FRST],
                     integ: hit[SIG_FINTA] | hit[SIG_FINTB],
                     inv:   hit[SIG_FINV],
                     smp:   hit[SIG_FSMP]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ccd_o   <= '0;
            p3_o    <= 1'b1;
            p4_o    <= 1'b1;
            fe_o    <= '0;
            valid_o <= 1'b0;
        end else begin
            ccd_o   <= ccd_nx;
            p3_o    <= !ccd_nx.ph1;
            p4_o    <= !ccd_nx.ph2;
            fe_o    <= fe_nx;
            valid_o <= (mode_i == MODE_READ);
        end
    end

    // R5: frozen sensor clocks do not move inside a hold period
    p_freeze_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == MODE_HOLD && $past(tick_i) != '0) |-> $stable(ccd_o));

    // R6: the valid flag changes only where a new period begins
    p_valid_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_o != $past(valid_o)) |-> ($past(tick_i) == '0));

endmodule

// File: rtl/ccd_clock_seq.sv
module ccd_clock_seq
    import ccdseq_pkg::*;
#(
    parameter int TICK_W = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              frame_start,
    output logic              ccd_p1,
    output logic              ccd_p2,
    output logic              ccd_p3,
    output logic              ccd_p4,
    output logic              ccd_tg,
    output logic              fe_rst,
    output logic              fe_int,
    output logic              fe_inv,
    output logic              fe_smp,
    output logic              row_valid
);
    logic [TICK_W-1:0] tick;
    logic              wrap;
    logic [TICK_W-1:0] act_on  [NSIG];
    logic [TICK_W-1:0] act_off [NSIG];
    logic [CNT_W-1:0]  hold_n;
    logic [CNT_W-1:0]  rows_n;
    mode_e             mode;
    ccd_lvl_t          ccd_lvl;
    fe_lvl_t           fe_lvl;

    ccdseq_tick #(.TICK_W(TICK_W)) tick_i (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick),
        .wrap_o (wrap)
    );

    ccdseq_cfg #(
        .TICK_W (TICK_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .wrap_i   (wrap),
        .we_i     (cfg_we),
        .addr_i   (cfg_addr),
        .wdata_i  (cfg_wdata),
        .on_o     (act_on),
        .off_o    (act_off),
        .hold_n_o (hold_n),
        .rows_n_o (rows_n)
    );

    ccdseq_frame #(.CNT_W(CNT_W)) frame_i (
        .clk      (clk),
        .rst      (rst),
        .wrap_i   (wrap),
        .start_i  (frame_start),
        .hold_n_i (hold_n),
        .rows_n_i (rows_n),
        .mode_o   (mode)
    );

    ccdseq_wave #(.TICK_W(TICK_W)) wave_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .on_i    (act_on),
        .off_i   (act_off),
        .mode_i  (mode),
        .ccd_o   (ccd_lvl),
        .p3_o    (ccd_p3),
        .p4_o    (ccd_p4),
        .fe_o    (fe_lvl),
        .valid_o (row_valid)
    );

    assign ccd_p1 = ccd_lvl.ph1;
    assign ccd_p2 = ccd_lvl.ph2;
    assign ccd_tg = ccd_lvl.tg;
    assign fe_rst = fe_lvl.rst;
    assign fe_int = fe_lvl.integ;
    assign fe_inv = fe_lvl.inv;
    assign fe_smp = fe_lvl.smp;

endmodule

// File: tb/ccd_clock_seq_tb_top.sv
`timescale 1ns/1ps
module ccd_clock_seq_tb_top;

    localparam int PER = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        frame_start;
    logic        ccd_p1, ccd_p2, ccd_p3, ccd_p4, ccd_tg;
    logic        fe_rst, fe_int, fe_inv, fe_smp, row_valid;

    always #2 clk = ~clk;

    ccd_clock_seq dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .ccd_p1      (ccd_p1),
        .ccd_p2      (ccd_p2),
        .ccd_p3      (ccd_p3),
        .ccd_p4      (ccd_p4),
        .ccd_tg      (ccd_tg),
        .fe_rst      (fe_rst),
        .fe_int      (fe_int),
        .fe_inv      (fe_inv),
        .fe_smp      (fe_smp),
        .row_valid   (row_valid)
    );

    typedef struct {
        int         n;
        logic [9:0] vec;
        string      tag;
    } item_t;

    item_t sbq[$];
    item_t it;
    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    bit    done  = 0;

    // bench model of the programmed edges (shadow view) and per-period frame plan
    int sh_on  [8];
    int sh_off [8];
    int mode_at [0:19];   // 0 idle, 1 hold, 2 read

    logic [9:0] obs;
    assign obs = {row_valid, fe_smp, fe_inv, fe_int, fe_rst,
                  ccd_tg, ccd_p4, ccd_p3, ccd_p2, ccd_p1};

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic logic win(int on, int off, int t);
        if (on < off) return (t >= on) && (t < off);
        if (on > off) return (t >= on) || (t < off);
        return 1'b0;
    endfunction

    // driver side: expected vectors for one whole period
    task automatic push_period(int p, string tag);
        item_t e;
        for (int t = 0; t < PER; t++) begin
            int   tc;
            logic a, b, g;
            tc = (mode_at[p] == 1) ? 0 : t;
            a  = win(sh_on[0], sh_off[0], tc);
            b  = win(sh_on[1], sh_off[1], tc);
            g  = win(sh_on[2], sh_off[2], tc);
            e.n   = PER * p + 1 + t;
            e.vec = {(mode_at[p] == 2),
                     win(sh_on[7], sh_off[7], t),
                     win(sh_on[6], sh_off[6], t),
                     win(sh_on[4], sh_off[4], t) | win(sh_on[5], sh_off[5], t),
                     win(sh_on[3], sh_off[3], t),
                     g, !b, !a, b, a};
            e.tag = tag;
            sbq.push_back(e);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a[4:0];
        cfg_wdata = d[15:0];
        @(negedge clk);
        cfg_we    = 1'b0;
        if (a < 16) begin
            if (a % 2 == 0) sh_on[a / 2]  = d;
            else            sh_off[a / 2] = d;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: compare every stamped expectation at its cycle
    always @(negedge clk) begin
        if (!rst) begin
            while (sbq.size() > 0 && sbq[0].n == cyc) begin
                it = sbq.pop_front();
                total++;
                if (obs !== it.vec) begin
                    bad++;
                    $display("FAIL %s edge %0d tick %0d: got %b exp %b",
                             it.tag, cyc, (cyc - 1) % PER, obs, it.vec);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running exp finished");
            summary();
        end
    end

    initial begin
        rst         = 1'b1;
        cfg_we      = 1'b0;
        cfg_addr    = '0;
        cfg_wdata   = '0;
        frame_start = 1'b0;
        for (int k = 0; k < 20; k++) mode_at[k] = 0;
        // R10: reset placement
        sh_on  = '{0, 64, 192, 0, 24, 104, 96, 176};
        sh_off = '{128, 192, 224, 16, 88, 168, 200, 184};

        repeat (4) @(negedge clk);
        // R3: reset levels, phases 3 and 4 high, all else low
        total++;
        if (obs !== 10'b00_0000_1100) begin
            bad++;
            $display("FAIL R3 reset levels: got %b exp %b", obs, 10'b00_0000_1100);
        end

        push_period(0, "R1 R10 R11");
        rst = 1'b0;

        wait_cyc(64);
        push_period(1, "R4 R10 R7");

        // period 1: wrapping phase 1, empty transfer gate (R2), visible from period 2 (R4)
        wait_cyc(PER + 64);
        wr(0, 200);
        wr(1, 40);
        wr(4, 77);
        wr(5, 77);
        push_period(2, "R2 R4");

        // period 2: hold 3, rows 2, start -> hold 3..5, read 6..7
        wait_cyc(2 * PER + 64);
        wr(16, 3);
        wr(17, 2);
        pulse_start();
        mode_at[3] = 1; mode_at[4] = 1; mode_at[5] = 1;
        mode_at[6] = 2; mode_at[7] = 2;
        push_period(3, "R5");

        // period 3: start while busy must be ignored (R8)
        wait_cyc(3 * PER + 64);
        pulse_start();
        push_period(4, "R5 R8");

        // period 4: move the sample strobe during the hold (R7)
        wait_cyc(4 * PER + 64);
        wr(14, 10);
        wr(15, 20);
        push_period(5, "R5 R7");

        wait_cyc(5 * PER + 64);
        push_period(6, "R6");
        wait_cyc(6 * PER + 64);
        push_period(7, "R6");
        wait_cyc(7 * PER + 64);
        push_period(8, "R8 R11");

        // period 8: no hold, one row (R9)
        wait_cyc(8 * PER + 64);
        wr(16, 0);
        wr(17, 1);
        pulse_start();
        mode_at[9] = 2;
        push_period(9, "R9");
        wait_cyc(9 * PER + 64);
        push_period(10, "R9 R11");

        // period 10: hold 2, zero rows (R9)
        wait_cyc(10 * PER + 64);
        wr(17, 0);
        wr(16, 2);
        pulse_start();
        mode_at[11] = 1; mode_at[12] = 1;
        push_period(11, "R9 R5");
        wait_cyc(11 * PER + 64);
        push_period(12, "R9");
        wait_cyc(12 * PER + 64);
        push_period(13, "R9 R11");

        wait_cyc(14 * PER + 8);
        total++;
        if (sbq.size() != 0) begin
            bad++;
            $display("FAIL R1 scoreboard drain: got %0d left exp 0", sbq.size());
        end
        summary();
    end

endmodule